// File: doc/BRIEF.md
# Strong-Signal IF Regenerator with Data-Sign Estimator

This block lives inside a correlator channel that is carrier-locked to a strong satellite signal. On every sample cycle it rebuilds a clean, noise-free copy of that signal at IF, in sign/magnitude form. A companion slave correlator despreads the copy so that the cross-correlation it causes can be removed after integration. The copy is the product of three terms: the prompt spreading-code chip, a guess of the current navigation data sign and the in-phase carrier reference. Amplitude scaling happens later and is not part of this block.

The data sign has to be known before the data bit has finished. It is therefore taken from a running sum of prompt in-phase products. While bit lock is absent, that sum starts over at every code epoch. Once bit lock is held, it starts over only at data-bit edges. An optional mode uses the sign of the previous completed sum during the first part of each epoch, while the new sum is still small. A continuous-wave mode holds the code chip at +1, so the copy is an unspread carrier.

Top module: `strong_if_regen`

## Requirements
- R1: Sign/magnitude encoding is bit 1 = positive (+1) and bit 0 = negative (-1), for `prn_chip`, `car_sign`, `out_sign` and the data-sign estimate. `out_sign` is registered and, one clock after the inputs, equals XNOR(XNOR(estimate, prn_chip), car_sign).
- R2: `out_mag` is registered and, one clock later, equals `car_mag`. A value of 0 stands for weight 1 and a value of 1 stands for weight 3.
- R3: The live estimate is the sign of the partial sum of `pi_in` samples held before the current cycle. A sum of exactly zero counts as positive.
- R4: While `bit_sync` is 0, a cycle with `epoch_stb` high restarts the partial sum. `bit_stb` has no effect in this state.
- R5: While `bit_sync` is 1, a cycle with `bit_stb` high restarts the partial sum. `epoch_stb` does not restart it in this state.
- R6: In a restart cycle, the output is built from the estimate held before the restart. The `pi_in` sample of that cycle closes the finished sum, and the sign of the finished sum is latched. The new sum begins empty.
- R7: With `early_mode` high, the latched sign of the last finished sum is used as the estimate. This holds until `HOLD_CHIPS` (default 250) `chip_stb` pulses have been counted since the last `epoch_stb`. After that, the live estimate is used.
- R8: With `cw_mode` high, the code chip is taken as +1 whatever the value of `prn_chip`.
- R9: During reset, `out_sign` is 1 and `out_mag` is 0. The partial sum is zero and the latched sign is positive.
- R10: The partial sum saturates at the limits of an `ACC_W`-bit signed value. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_stb | input | 1 | One pulse per prompt code chip |
| prn_chip | input | 1 | Prompt code chip, 1 = +1 |
| car_sign | input | 1 | In-phase carrier sign, 1 = positive |
| car_mag | input | 1 | In-phase carrier magnitude bit |
| pi_in | input | PI_W | Signed prompt in-phase product for this sample |
| epoch_stb | input | 1 | Code epoch end strobe |
| bit_stb | input | 1 | Data-bit boundary strobe from the bit counter |
| bit_sync | input | 1 | Bit lock held |
| early_mode | input | 1 | Use the latched sign early in each epoch |
| cw_mode | input | 1 | Force the code chip to +1 |
| out_sign | output | 1 | Rebuilt sample sign |
| out_mag | output | 1 | Rebuilt sample magnitude bit |

## Verification
In one cycle the block can both use the data-sign estimate to build the output and restart the sum that the estimate comes from. The bench provokes this by first driving the sum negative and then raising the restart strobe that is valid for the current lock state, together with a code/carrier pattern whose output depends on the estimate. The output of that cycle must still carry the old negative sign. The first probe after it must show a positive sign, because the new sum is empty. The finished negative sign must then appear again through the early-epoch mode.

// File: rtl/sir_pkg.sv
package sir_pkg;

  // Product of sign-coded +/-1 terms: equal signs give positive (1).
  function automatic logic sm_mul(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

  // Full rebuilt sign: data estimate x code chip x carrier sign.
  function automatic logic rebuild_sign(input logic est, input logic chip,
                                        input logic carrier);
    return sm_mul(sm_mul(est, chip), carrier);
  endfunction

endpackage

// File: rtl/sir_partial_acc.sv
module sir_partial_acc #(
  parameter int PI_W  = 4,
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PI_W-1:0]  pi_in,
  input  logic                    restart,
  output logic                    live_pos,
  output logic                    dump_pos,
  output logic                    acc_zero
);

  localparam logic [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};
  localparam int               EXT_W = ACC_W + 1 - PI_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next_sum;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [PI_W-1:0]  b);
    logic [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {{EXT_W{b[PI_W-1]}}, b};
    if (s[ACC_W] != s[ACC_W-1])
      return s[ACC_W] ? MIN_V : MAX_V;
    return s[ACC_W-1:0];
  endfunction

  assign acc_next_sum = sat_add(acc_q, pi_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      dump_pos <= 1'b1;
    end else if (restart) begin
      acc_q    <= '0;
      dump_pos <= ~acc_next_sum[ACC_W-1];
    end else begin
      acc_q    <= acc_next_sum;
    end
  end

  assign live_pos = ~acc_q[ACC_W-1];
  assign acc_zero = (acc_q == '0);

endmodule

// File: rtl/sir_epoch_window.sv
module sir_epoch_window #(
  parameter int EPOCH_CHIPS = 1023,
  parameter int HOLD_CHIPS  = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic epoch_stb,
  input  logic chip_stb,
  output logic win_active
);

  localparam int               CNT_W  = $clog2(EPOCH_CHIPS + 1);
  localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(EPOCH_CHIPS);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CHIPS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (epoch_stb)
      cnt_q <= '0;
    else if (chip_stb && cnt_q != TOP_V)
      cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HOLD_CHIPS == 0) begin : g_no_hold
      assign win_active = 1'b0;
    end else begin : g_hold
      assign win_active = (cnt_q < HOLD_V);
    end
  endgenerate

endmodule

// File: rtl/sir_mixer.sv
module sir_mixer
  import sir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic est_bit,
  input  logic prn_chip,
  input  logic cw_mode,
  input  logic car_sign,
  input  logic car_mag,
  output logic out_sign,
  output logic out_mag
);

  logic chip_eff;

  assign chip_eff = cw_mode | prn_chip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sign <= 1'b1;
      out_mag  <= 1'b0;
    end else begin
      out_sign <= rebuild_sign(est_bit, chip_eff, car_sign);
      out_mag  <= car_mag;
    end
  end

endmodule

// File: rtl/strong_if_regen.sv
module strong_if_regen #(
  parameter int PI_W        = 4,
  parameter int ACC_W       = 16,
  parameter int EPOCH_CHIPS = 1023,
  parameter int HOLD_CHIPS  = 250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chip_stb,
  input  logic                   prn_chip,
  input  logic                   car_sign,
  input  logic                   car_mag,
  input  logic signed [PI_W-1:0] pi_in,
  input  logic                   epoch_stb,
  input  logic                   bit_stb,
  input  logic                   bit_sync,
  input  logic                   early_mode,
  input  logic                   cw_mode,
  output logic                   out_sign,
  output logic                   out_mag
);

  // Named internal events, visible to the bound checker.
  logic restart_evt;
  logic live_pos;
  logic dump_pos;
  logic acc_zero;
  logic win_active;
  logic est_bit;

  assign restart_evt = bit_sync ? bit_stb : epoch_stb;
  assign est_bit     = (early_mode && win_active) ? dump_pos : live_pos;

  sir_partial_acc #(.PI_W(PI_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .pi_in    (pi_in),
    .restart  (restart_evt),
    .live_pos (live_pos),
    .dump_pos (dump_pos),
    .acc_zero (acc_zero)
  );

  sir_epoch_window #(.EPOCH_CHIPS(EPOCH_CHIPS), .HOLD_CHIPS(HOLD_CHIPS)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .epoch_stb  (epoch_stb),
    .chip_stb   (chip_stb),
    .win_active (win_active)
  );

  sir_mixer u_mix (
    .clk      (clk),
    .rst_n    (rst_n),
    .est_bit  (est_bit),
    .prn_chip (prn_chip),
    .cw_mode  (cw_mode),
    .car_sign (car_sign),
    .car_mag  (car_mag),
    .out_sign (out_sign),
    .out_mag  (out_mag)
  );

endmodule

// File: rtl/sir_checker.sv
module sir_checker (
  input logic clk,
  input logic rst_n,
  input logic prn_chip,
  input logic car_sign,
  input logic car_mag,
  input logic cw_mode,
  input logic early_mode,
  input logic bit_sync,
  input logic epoch_stb,
  input logic bit_stb,
  input logic out_sign,
  input logic out_mag,
  input logic est_bit,
  input logic live_pos,
  input logic dump_pos,
  input logic win_active,
  input logic acc_zero
);

  // R1
  sign_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_mode |=> out_sign == (($past(est_bit) ~^ $past(prn_chip)) ~^ $past(car_sign)));

  // R2
  mag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_mag == $past(car_mag));

  // R3
  live_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !early_mode |-> est_bit == live_pos);

  // R3
  empty_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zero |-> live_pos);

  // R4
  epoch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_sync && epoch_stb) |=> acc_zero);

  // R5
  bit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_sync && bit_stb) |=> acc_zero);

  // R7
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early_mode && win_active) |-> est_bit == dump_pos);

  // R8
  cw_unspread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_mode |=> out_sign == ($past(est_bit) ~^ $past(car_sign)));

endmodule

bind strong_if_regen sir_checker chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prn_chip   (prn_chip),
  .car_sign   (car_sign),
  .car_mag    (car_mag),
  .cw_mode    (cw_mode),
  .early_mode (early_mode),
  .bit_sync   (bit_sync),
  .epoch_stb  (epoch_stb),
  .bit_stb    (bit_stb),
  .out_sign   (out_sign),
  .out_mag    (out_mag),
  .est_bit    (est_bit),
  .live_pos   (live_pos),
  .dump_pos   (dump_pos),
  .win_active (win_active),
  .acc_zero   (acc_zero)
);

// File: tb/strong_if_regen_test.sv
`timescale 1ns/1ps
module strong_if_regen_test;

  localparam int PI_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_stb = 1'b0, prn_chip = 1'b0, car_sign = 1'b0, car_mag = 1'b0;
  logic signed [PI_W-1:0] pi_in = '0;
  logic epoch_stb = 1'b0, bit_stb = 1'b0, bit_sync = 1'b0;
  logic early_mode = 1'b0, cw_mode = 1'b0;
  logic out_sign, out_mag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strong_if_regen uut (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .prn_chip(prn_chip),
    .car_sign(car_sign), .car_mag(car_mag), .pi_in(pi_in),
    .epoch_stb(epoch_stb), .bit_stb(bit_stb), .bit_sync(bit_sync),
    .early_mode(early_mode), .cw_mode(cw_mode),
    .out_sign(out_sign), .out_mag(out_mag)
  );

  // Rows {cw, prn, car_sign, car_mag, exp_sign, exp_mag}, estimate positive.
  localparam logic [5:0] VEC [8] = '{
    6'b000010, 6'b001101, 6'b010101, 6'b011010,
    6'b100000, 6'b101111, 6'b110000, 6'b111111
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic got_s, input logic exp_s,
                       input logic got_m, input logic exp_m);
    checks++;
    if (got_s !== exp_s || got_m !== exp_m) begin
      errors++;
      $display("FAIL %s: sign/mag got %b/%b expected %b/%b",
               req, got_s, got_m, exp_s, exp_m);
    end
  endtask

  // One quiet cycle with a chosen code/carrier pattern, then compare.
  task automatic probe(input string req, input logic prn, input logic cs,
                       input logic cm, input logic cw, input logic exp_s);
    pi_in = '0; chip_stb = 0; epoch_stb = 0; bit_stb = 0;
    prn_chip = prn; car_sign = cs; car_mag = cm; cw_mode = cw;
    step();
    check(req, out_sign, exp_s, out_mag, cm);
    cw_mode = 0;
  endtask

  task automatic feed(input logic signed [PI_W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      pi_in = v;
      step();
    end
    pi_in = '0;
  endtask

  initial begin
    #9;
    check("R9 reset", out_sign, 1'b1, out_mag, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", out_sign, 1'b1, out_mag, 1'b0);

    // Table walk: empty sum gives a positive estimate (R1, R2, R3, R8).
    for (int k = 0; k < 8; k++) begin
      cw_mode = VEC[k][5]; prn_chip = VEC[k][4];
      car_sign = VEC[k][3]; car_mag = VEC[k][2];
      step();
      check("R1/R2/R8 table", out_sign, VEC[k][1], out_mag, VEC[k][0]);
    end
    cw_mode = 0;

    // Negative sum.
    feed(-4'sd3, 1);
    probe("R3 negative estimate", 1, 1, 0, 0, 1'b0);
    probe("R8 cw ignores chip", 0, 1, 1, 1, 1'b0);
    probe("R1 chip flips sign", 0, 1, 0, 0, 1'b1);

    // No bit lock: bit strobe ignored, epoch restarts.
    bit_stb = 1; step(); bit_stb = 0;
    probe("R4 bit strobe ignored", 1, 1, 0, 0, 1'b0);
    prn_chip = 1; car_sign = 1; car_mag = 1; epoch_stb = 1;
    step();
    epoch_stb = 0;
    check("R6 restart cycle uses old estimate", out_sign, 1'b0, out_mag, 1'b1);
    probe("R4 epoch restart empties sum", 1, 1, 0, 0, 1'b1);

    // Early mode: latched negative sign for HOLD_CHIPS chips.
    early_mode = 1;
    probe("R7 latched sign early", 1, 1, 0, 0, 1'b0);
    chip_stb = 1; step(); chip_stb = 0;
    for (int i = 1; i < 249; i++) begin chip_stb = 1; step(); end
    chip_stb = 0;
    probe("R7 still early at 249 chips", 1, 1, 1, 0, 1'b0);
    chip_stb = 1; step(); chip_stb = 0;
    probe("R7 live sign at 250 chips", 1, 1, 0, 0, 1'b1);
    early_mode = 0;

    // Bit lock: epoch ignored, bit strobe restarts.
    bit_sync = 1;
    feed(-4'sd2, 1);
    epoch_stb = 1; step(); epoch_stb = 0;
    probe("R5 epoch ignored under bit lock", 1, 1, 0, 0, 1'b0);
    bit_stb = 1; step(); bit_stb = 0;
    probe("R5 bit strobe restarts", 1, 1, 0, 0, 1'b1);
    bit_sync = 0;

    // Saturation.
    feed(-4'sd8, 5000);
    probe("R10 deep negative", 1, 1, 0, 0, 1'b0);
    feed(4'sd7, 4682);
    probe("R10 recovers from floor", 1, 1, 1, 0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule